// File: doc/BRIEF.md
# Tracking Angle Counter Interface

This block is the digital side of a tracking shaft-angle converter. An external rate source, typically a voltage-controlled oscillator that closes the analog error loop, delivers one step strobe per angle increment together with a direction bit. The block moves a 16-bit natural-binary angle by one least significant step of the selected resolution per strobe. In this angle format the top bit weighs 180 degrees, the next bit 90 degrees, and so on down the word.

Around the counter sit the features a host processor needs to read and steer the angle:
- a read view that can be frozen while the counter keeps tracking;
- a preset path that loads the angle from the data bus;
- an output-enable qualifier for the bus pad drivers;
- a one-cycle change pulse for every step;
- a registered direction flag;
- a wrap pulse each time the angle passes through zero, which external logic uses to count whole turns.

All inputs are synchronous to one system clock. Reset is synchronous and active high.

Top module: `angle_track_counter`

## Requirements
- R1: `res_code` selects the resolution: 2'b00 = 10 bits, 2'b01 = 12 bits, 2'b10 = 14 bits, 2'b11 = 16 bits. The weight of one step is bit 6, bit 4, bit 2 or bit 0 of the angle respectively.
- R2: Angle bits below the selected step weight always read 0. After a change of `res_code`, the bits that become unused are cleared on the next clock.
- R3: A cycle with `step_pulse` = 1 and `preset_mode` = 0 adds one step weight to the angle when `step_dir` = 1 and subtracts one when `step_dir` = 0, modulo 2^16. A full turn therefore takes 1024, 4096, 16384 or 65536 steps.
- R4: While `preset_mode` = 1 the counter loads `bus_i` with the unused low bits cleared. The preset wins over a step in the same cycle, and that cycle raises no `busy`.
- R5: `bus_oe` is 1 only when `out_en_n` = 0 and `preset_mode` = 0. Otherwise it is 0, and the bus pins are inputs or high impedance.
- R6: `bus_o` shows the counter one clock after it changes. While `freeze_n` = 0 it holds the value it had when the freeze began, and the counter keeps tracking underneath.
- R7: `busy` is a one-cycle pulse in the cycle after each accepted step, and is 0 otherwise.
- R8: `dir_cw` holds the direction of the most recent accepted step: 1 = up (clockwise), 0 = down (counter-clockwise).
- R9: `ripple` pulses together with `busy` when a step wraps the angle from all ones to zero, or from zero to all ones, at the current resolution. It is 0 for all other steps.
- R10: After reset the angle is 0, `busy` and `ripple` are 0 and `dir_cw` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_pulse | input | 1 | One angle step per cycle while high |
| step_dir | input | 1 | Step direction, 1 = up |
| res_code | input | 2 | Resolution select |
| out_en_n | input | 1 | Active-low bus output enable |
| freeze_n | input | 1 | Active-low read-view freeze |
| preset_mode | input | 1 | 1 = bus is input and presets the angle |
| bus_i | input | 16 | Bus value seen at the pins |
| bus_o | output | 16 | Angle value for the pin drivers |
| bus_oe | output | 1 | Pin driver enable |
| busy | output | 1 | Change pulse, one per step |
| dir_cw | output | 1 | Direction of the last step |
| ripple | output | 1 | Zero-crossing pulse for turns counting |

## Verification
Steps are applied up and down at full resolution. This separates the add and subtract paths and shows the direction flag following them. Wraps through zero in each direction, at 16 and at 14 bits, test the all-ones detection against the resolution mask. A run of 1024 steps at 10 bits must end at zero with exactly one ripple, which confirms the step weight for one full turn. Presets with low bits set, a resolution change with stale low bits, a preset that collides with a step, and steps taken under a freeze show apart the masking, the priority rule and the split between the live counter and the read view.

// File: rtl/angle_pkg.sv
package angle_pkg;

    localparam int ANGLE_W = 16;

    typedef logic [ANGLE_W-1:0] angle_t;

    typedef enum logic [1:0] {
        RES_10 = 2'b00,
        RES_12 = 2'b01,
        RES_14 = 2'b10,
        RES_16 = 2'b11
    } res_e;

    typedef struct packed {
        logic busy;
        logic ripple;
        logic dir_up;
    } track_flags_t;

    function automatic int res_bits(res_e r);
        int b;
        b = ANGLE_W;
        case (r)
            RES_10: b = 10;
            RES_12: b = 12;
            RES_14: b = 14;
            RES_16: b = 16;
        endcase
        return b;
    endfunction

    function automatic angle_t lsb_weight(res_e r);
        return angle_t'(1) << (ANGLE_W - res_bits(r));
    endfunction

    function automatic angle_t keep_mask(res_e r);
        return ~(lsb_weight(r) - angle_t'(1));
    endfunction

endpackage

// File: rtl/angle_step_core.sv
module angle_step_core
    import angle_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         dir_up,
    input  res_e         res,
    input  logic         load,
    input  angle_t       preset,
    output angle_t       cnt,
    output track_flags_t flags
);

    angle_t mask;
    angle_t cur;
    angle_t wt;
    angle_t nxt;
    logic   wrap;

    always_comb begin
        mask = keep_mask(res);
        wt   = lsb_weight(res);
        cur  = cnt & mask;
        nxt  = (dir_up ? (cur + wt) : (cur - wt)) & mask;
        wrap = dir_up ? (nxt == '0) : (cur == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt          <= '0;
            flags.busy   <= 1'b0;
            flags.ripple <= 1'b0;
            flags.dir_up <= 1'b1;
        end else if (load) begin
            cnt          <= preset & mask;
            flags.busy   <= 1'b0;
            flags.ripple <= 1'b0;
        end else if (step) begin
            cnt          <= nxt;
            flags.busy   <= 1'b1;
            flags.ripple <= wrap;
            flags.dir_up <= dir_up;
        end else begin
            cnt          <= cur;
            flags.busy   <= 1'b0;
            flags.ripple <= 1'b0;
        end
    end

    // R2
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(res) |-> ((cnt & ~keep_mask(res)) == '0));

    // R3
    step_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (cnt != $past(cnt)));

    // R4
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> !flags.busy);

    // R8
    dir_follow_chk: assert property (@(posedge clk) disable iff (rst)
        flags.busy |-> (flags.dir_up == $past(dir_up)));

    // R9
    ripple_busy_chk: assert property (@(posedge clk) disable iff (rst)
        flags.ripple |-> flags.busy);

endmodule

// File: rtl/angle_read_latch.sv
module angle_read_latch
    import angle_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   freeze_n,
    input  angle_t live,
    output angle_t view
);

    always_ff @(posedge clk) begin
        if (rst)
            view <= '0;
        else if (freeze_n)
            view <= live;
    end

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !freeze_n |=> $stable(view));

endmodule

// File: rtl/angle_track_counter.sv
module angle_track_counter
    import angle_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step_pulse,
    input  logic               step_dir,
    input  logic [1:0]         res_code,
    input  logic               out_en_n,
    input  logic               freeze_n,
    input  logic               preset_mode,
    input  logic [ANGLE_W-1:0] bus_i,
    output logic [ANGLE_W-1:0] bus_o,
    output logic               bus_oe,
    output logic               busy,
    output logic               dir_cw,
    output logic               ripple
);

    res_e         res;
    angle_t       cnt;
    angle_t       view;
    track_flags_t flags;

    assign res = res_e'(res_code);

    angle_step_core u_core (
        .clk    (clk),
        .rst    (rst),
        .step   (step_pulse),
        .dir_up (step_dir),
        .res    (res),
        .load   (preset_mode),
        .preset (bus_i),
        .cnt    (cnt),
        .flags  (flags)
    );

    angle_read_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .freeze_n (freeze_n),
        .live     (cnt),
        .view     (view)
    );

    assign bus_o  = view;
    assign bus_oe = !out_en_n && !preset_mode;
    assign busy   = flags.busy;
    assign ripple = flags.ripple;
    assign dir_cw = flags.dir_up;

    // R5
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (out_en_n || preset_mode) |-> !bus_oe);

endmodule

// File: tb/test_angle_track_counter.sv
module test_angle_track_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_pulse = 1'b0;
    logic        step_dir = 1'b1;
    logic [1:0]  res_code = 2'b11;
    logic        out_en_n = 1'b0;
    logic        freeze_n = 1'b1;
    logic        preset_mode = 1'b0;
    logic [15:0] bus_i = '0;
    logic [15:0] bus_o;
    logic        bus_oe;
    logic        busy;
    logic        dir_cw;
    logic        ripple;

    int n_chk = 0;
    int n_bad = 0;
    logic last_busy;
    logic last_ripple;

    always #5 clk = ~clk;

    angle_track_counter i_angle_track_counter (
        .clk(clk), .rst(rst), .step_pulse(step_pulse), .step_dir(step_dir),
        .res_code(res_code), .out_en_n(out_en_n), .freeze_n(freeze_n),
        .preset_mode(preset_mode), .bus_i(bus_i), .bus_o(bus_o),
        .bus_oe(bus_oe), .busy(busy), .dir_cw(dir_cw), .ripple(ripple)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step_once(input logic up);
        step_pulse = 1'b1;
        step_dir   = up;
        @(negedge clk);
        step_pulse  = 1'b0;
        last_busy   = busy;
        last_ripple = ripple;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic preset(input logic [15:0] v);
        preset_mode = 1'b1;
        bus_i       = v;
        @(negedge clk);
        preset_mode = 1'b0;
        settle();
    endtask

    task automatic t_reset();
        chk("R10 angle", 32'(bus_o), 32'h0);
        chk("R10 busy", 32'(busy), 32'h0);
        chk("R10 ripple", 32'(ripple), 32'h0);
        chk("R10 dir", 32'(dir_cw), 32'h1);
    endtask

    task automatic t_step_16();
        res_code = 2'b11;
        preset(16'h1000);
        step_once(1'b1);
        chk("R7 busy on step", 32'(last_busy), 32'h1);
        chk("R9 no ripple mid", 32'(last_ripple), 32'h0);
        chk("R8 dir up", 32'(dir_cw), 32'h1);
        settle();
        chk("R3 up one", 32'(bus_o), 32'h1001);
        chk("R7 busy ends", 32'(busy), 32'h0);
        step_once(1'b0);
        step_once(1'b0);
        chk("R8 dir down", 32'(dir_cw), 32'h0);
        settle();
        chk("R3 down two", 32'(bus_o), 32'h0FFF);
    endtask

    task automatic t_wrap();
        res_code = 2'b11;
        preset(16'hFFFF);
        step_once(1'b1);
        chk("R9 ripple up", 32'(last_ripple), 32'h1);
        settle();
        chk("R9 wrap to zero", 32'(bus_o), 32'h0);
        step_once(1'b0);
        chk("R9 ripple down", 32'(last_ripple), 32'h1);
        settle();
        chk("R9 wrap to ones", 32'(bus_o), 32'hFFFF);
        res_code = 2'b10;
        preset(16'hFFFC);
        step_once(1'b1);
        chk("R9 ripple 14b", 32'(last_ripple), 32'h1);
        settle();
        chk("R1 14b wrap", 32'(bus_o), 32'h0);
    endtask

    task automatic t_res_change();
        res_code = 2'b11;
        preset(16'h1234);
        chk("R4 preset 16b", 32'(bus_o), 32'h1234);
        res_code = 2'b00;
        settle();
        settle();
        chk("R2 clear on res change", 32'(bus_o), 32'h1200);
        step_once(1'b1);
        settle();
        chk("R1 10b step weight", 32'(bus_o), 32'h1240);
        res_code = 2'b01;
        preset(16'hABCD);
        chk("R2 preset masked 12b", 32'(bus_o), 32'hABC0);
        step_once(1'b0);
        settle();
        chk("R1 12b step weight", 32'(bus_o), 32'hABB0);
    endtask

    task automatic t_full_turn();
        int ripples = 0;
        res_code = 2'b00;
        preset(16'h0000);
        for (int i = 0; i < 1024; i++) begin
            step_once(1'b1);
            if (last_ripple) ripples++;
        end
        settle();
        chk("R3 10b full turn", 32'(bus_o), 32'h0);
        chk("R9 one ripple per turn", 32'(ripples), 32'd1);
    endtask

    task automatic t_priority();
        res_code = 2'b11;
        preset(16'h4000);
        preset_mode = 1'b1;
        bus_i       = 16'h2222;
        step_pulse  = 1'b1;
        step_dir    = 1'b1;
        @(negedge clk);
        chk("R4 no busy on preset", 32'(busy), 32'h0);
        preset_mode = 1'b0;
        step_pulse  = 1'b0;
        settle();
        chk("R4 preset beats step", 32'(bus_o), 32'h2222);
    endtask

    task automatic t_freeze();
        res_code = 2'b11;
        preset(16'h0100);
        freeze_n = 1'b0;
        for (int i = 0; i < 5; i++) step_once(1'b1);
        settle();
        chk("R6 held while frozen", 32'(bus_o), 32'h0100);
        freeze_n = 1'b1;
        settle();
        chk("R6 tracked under freeze", 32'(bus_o), 32'h0105);
    endtask

    task automatic t_oe();
        out_en_n = 1'b1;
        #1;
        chk("R5 oe off", 32'(bus_oe), 32'h0);
        out_en_n = 1'b0;
        #1;
        chk("R5 oe on", 32'(bus_oe), 32'h1);
        preset_mode = 1'b1;
        bus_i       = bus_o;
        #1;
        chk("R5 oe off in preset", 32'(bus_oe), 32'h0);
        @(negedge clk);
        preset_mode = 1'b0;
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        t_reset();
        t_step_16();
        t_wrap();
        t_res_change();
        t_full_turn();
        t_priority();
        t_freeze();
        t_oe();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule